// File: doc/BRIEF.md
# Zero-Cross Gain Update Sequencer

This block holds the gain codes of a two-channel (left and right) attenuator and decides when a newly written code reaches the attenuator. A normal write stores the code as pending and marks the channel busy. The code moves to the active output on the next positive-going zero-crossing pulse of that channel. If no crossing comes, it moves when a tick-driven timeout expires. Applying the change at a crossing keeps a step in gain from producing an audible click.

The block also handles several other cases:
- Instant writes skip the wait.
- An active-low mute pin sends both channels to code 0. Raising the pin again restores the stored codes. Both transitions wait for a crossing or the timeout.
- Power-on leaves both channels muted.
- A test-mode flag mutes the outputs and blocks writes. The one exception is a force command, which loads one code into both channels at once.

Per-channel busy bits show whether a commit is still pending.

Top module: `gain_commit_seq`

## Requirements
- R1: A normal write (`wr_en`=1, `wr_instant`=0) stores `wr_data` for every channel selected in `wr_sel`. Bit 1 selects left and bit 0 selects right. The active code of that channel does not change until a pulse on its own `zc_pulse` bit. The code is then visible on `gain_out` after that clock edge. A pulse on the other channel's bit has no effect on it.
- R2: If no crossing arrives, a pending code is committed on the clock edge that samples the `TMO_TICKS`-th `tick` pulse after the write.
- R3: A write to a busy channel replaces its pending code and restarts the timeout count. The replaced code never appears on `gain_out`.
- R4: `busy` bit 1 belongs to left and bit 0 to right. A bit reads 1 from the edge that accepts the write until the edge that commits the code. So 2'b00 means both ready, 2'b01 right busy, 2'b10 left busy and 2'b11 both busy.
- R5: A write with `wr_sel`=2'b11 arms both channels with the same code. Each channel then commits on its own crossing, in whichever order the crossings arrive.
- R6: An instant write (`wr_instant`=1) puts the code on `gain_out` at the next clock edge and leaves the channel's busy bit at 0.
- R7: After reset both codes read 0 (mute) and both busy bits read 0, whatever the level of `mute_n`. Raising `mute_n` while the stored codes are 0 does not arm either channel.
- R8: A fall of `mute_n` arms both channels, each with target code 0. A rise arms both with their stored codes. Each channel arms only if it is busy or its target differs from its active code. Arming happens on the second clock edge after the pin changes. Writes made while the pin is low update only the stored code.
- R9: While `test_mode`=1, `gain_out` reads 0 and normal and instant writes are ignored. The stored codes and busy bits are unchanged when test mode ends.
- R10: While `test_mode`=1, `force_en`=1 loads `wr_data` into the stored and active codes of both channels at the next edge and clears both busy bits. The value appears on `gain_out` once test mode ends.
- R11: A crossing and a timeout in the same cycle give one commit. The channel is ready afterwards and further ticks leave it ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Gain write strobe, one cycle per completed command |
| wr_instant | input | 1 | Qualifies the write as instant |
| wr_sel | input | 2 | Channel select: bit 1 left, bit 0 right |
| wr_data | input | GAIN_W | Gain code (0 = mute); also the force value |
| force_en | input | 1 | Force-latch strobe, accepted only in test mode |
| test_mode | input | 1 | Test mode: outputs muted, writes blocked |
| mute_n | input | 1 | Mute pin, low mutes both channels |
| zc_pulse | input | 2 | Rising zero-crossing pulses: bit 1 left, bit 0 right |
| tick | input | 1 | Timebase pulse for the timeout counter |
| gain_out | output | 2*GAIN_W | Active codes: [2*GAIN_W-1:GAIN_W] left, [GAIN_W-1:0] right |
| busy | output | 2 | Pending-commit flags: bit 1 left, bit 0 right |

## Verification
The bench builds the block with `GAIN_W`=8 and `TMO_TICKS`=4. A 4-tick timeout lets every tick of a timeout window be checked one at a time, so a commit one tick early or late is caught. It also makes the restart after a rewrite visible with only a handful of pulses. A sweep of distinct codes over both channels checks that crossings are routed to the right channel. Directed sequences then cover mute-pin arming on both edges, test-mode blocking and the coincident crossing-and-timeout case.

// File: rtl/gcs_pkg.sv
package gcs_pkg;
    localparam int NUM_CH   = 2;
    localparam int CH_RIGHT = 0;
    localparam int CH_LEFT  = 1;

    typedef enum logic [1:0] {
        EV_NONE    = 2'd0,
        EV_NORMAL  = 2'd1,
        EV_INSTANT = 2'd2,
        EV_FORCE   = 2'd3
    } chan_ev_e;
endpackage

// File: rtl/gcs_mute_track.sv
module gcs_mute_track (
    input  logic clk,
    input  logic rst_n,
    input  logic mute_n,
    output logic muted,
    output logic mute_edge
);
    typedef struct packed {
        logic now;
        logic prev;
    } mt_state_t;

    mt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.now  = ~mute_n;
        st_d.prev = st_q.now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{now: 1'b1, prev: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign muted     = st_q.now;
    assign mute_edge = st_q.now ^ st_q.prev;
endmodule

// File: rtl/gcs_chan.sv
module gcs_chan
    import gcs_pkg::*;
#(
    parameter int GAIN_W    = 8,
    parameter int TMO_TICKS = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  chan_ev_e          ev,
    input  logic [GAIN_W-1:0] data,
    input  logic              zc,
    input  logic              tick,
    input  logic              muted,
    input  logic              mute_edge,
    output logic [GAIN_W-1:0] active,
    output logic              busy
);
    localparam int CW = (TMO_TICKS > 1) ? $clog2(TMO_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TMO_TICKS - 1);

    typedef struct packed {
        logic [GAIN_W-1:0] stored;
        logic [GAIN_W-1:0] active;
        logic              busy;
        logic [CW-1:0]     cnt;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic [GAIN_W-1:0] target;
    logic              tmo_hit;

    always_comb begin
        st_d    = st_q;
        target  = muted ? '0 : st_q.stored;
        tmo_hit = tick && (st_q.cnt == LAST);
        unique case (ev)
            EV_FORCE: begin
                st_d.stored = data;
                st_d.active = data;
                st_d.busy   = 1'b0;
                st_d.cnt    = '0;
            end
            EV_INSTANT: begin
                st_d.stored = data;
                st_d.active = muted ? '0 : data;
                st_d.busy   = 1'b0;
                st_d.cnt    = '0;
            end
            EV_NORMAL: begin
                st_d.stored = data;
                st_d.busy   = 1'b1;
                st_d.cnt    = '0;
            end
            default: begin
                if (st_q.busy && (zc || tmo_hit)) begin
                    st_d.active = target;
                    st_d.busy   = 1'b0;
                    st_d.cnt    = '0;
                end else if (st_q.busy && tick) begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
                if (mute_edge && (st_d.busy || (target != st_d.active))) begin
                    st_d.busy = 1'b1;
                    st_d.cnt  = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.active;
    assign busy   = st_q.busy;
endmodule

// File: rtl/gain_commit_seq.sv
module gain_commit_seq
    import gcs_pkg::*;
#(
    parameter int GAIN_W    = 8,
    parameter int TMO_TICKS = 22
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       wr_instant,
    input  logic [NUM_CH-1:0]          wr_sel,
    input  logic [GAIN_W-1:0]          wr_data,
    input  logic                       force_en,
    input  logic                       test_mode,
    input  logic                       mute_n,
    input  logic [NUM_CH-1:0]          zc_pulse,
    input  logic                       tick,
    output logic [NUM_CH*GAIN_W-1:0]   gain_out,
    output logic [NUM_CH-1:0]          busy
);
    logic muted;
    logic mute_edge;

    gcs_mute_track i_mute (
        .clk       (clk),
        .rst_n     (rst_n),
        .mute_n    (mute_n),
        .muted     (muted),
        .mute_edge (mute_edge)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        chan_ev_e          ev;
        logic [GAIN_W-1:0] act;

        always_comb begin
            if (test_mode && force_en) begin
                ev = EV_FORCE;
            end else if (!test_mode && wr_en && wr_sel[c]) begin
                ev = wr_instant ? EV_INSTANT : EV_NORMAL;
            end else begin
                ev = EV_NONE;
            end
        end

        gcs_chan #(
            .GAIN_W    (GAIN_W),
            .TMO_TICKS (TMO_TICKS)
        ) i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .ev        (ev),
            .data      (wr_data),
            .zc        (zc_pulse[c]),
            .tick      (tick),
            .muted     (muted),
            .mute_edge (mute_edge),
            .active    (act),
            .busy      (busy[c])
        );

        assign gain_out[c*GAIN_W +: GAIN_W] = test_mode ? '0 : act;
    end
endmodule

// File: rtl/gcs_checker.sv
module gcs_checker #(
    parameter int GAIN_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [1:0]            wr_sel,
    input logic                  force_en,
    input logic                  test_mode,
    input logic [1:0]            zc_pulse,
    input logic [2*GAIN_W-1:0]   gain_out,
    input logic [1:0]            busy,
    input logic                  mute_edge
);
    // R4: a busy bit only rises after an accepted write or a mute-pin edge
    a_r4_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy[0]) |-> $past((wr_en && !test_mode && wr_sel[0]) || mute_edge));

    // R1: a crossing on a busy channel, with nothing else going on, commits it
    a_r1_zc_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (busy[1] && zc_pulse[1] && !wr_en && !force_en && !mute_edge) |=> !busy[1]);

    // R1: an idle channel keeps its active code until a write or force
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy[0] && !wr_en && !force_en && !test_mode) |=>
            (test_mode || $stable(gain_out[GAIN_W-1:0])));

    // R9: writes in test mode never arm a channel
    a_r9_test_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && !force_en && !mute_edge && busy == 2'b00) |=> busy == 2'b00);
endmodule

bind gain_commit_seq gcs_checker #(.GAIN_W(GAIN_W)) i_gcs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .force_en  (force_en),
    .test_mode (test_mode),
    .zc_pulse  (zc_pulse),
    .gain_out  (gain_out),
    .busy      (busy),
    .mute_edge (mute_edge)
);

// File: tb/test_gain_commit_seq.sv
`timescale 1ns/1ps
module test_gain_commit_seq;
    localparam int GW  = 8;
    localparam int TMO = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, wr_instant = 1'b0, force_en = 1'b0;
    logic          test_mode = 1'b0, mute_n = 1'b0, tick = 1'b0;
    logic [1:0]    wr_sel = 2'b00, zc_pulse = 2'b00;
    logic [GW-1:0] wr_data = '0;
    logic [2*GW-1:0] gain_out;
    logic [1:0]    busy;

    int n_run = 0, n_fail = 0;
    int el = 0, er = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    gain_commit_seq #(.GAIN_W(GW), .TMO_TICKS(TMO)) i_gain_commit_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_instant(wr_instant),
        .wr_sel(wr_sel), .wr_data(wr_data), .force_en(force_en),
        .test_mode(test_mode), .mute_n(mute_n), .zc_pulse(zc_pulse),
        .tick(tick), .gain_out(gain_out), .busy(busy)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input int l, input int r, input int b);
        check({tag, " left"},  int'(gain_out[2*GW-1:GW]), l);
        check({tag, " right"}, int'(gain_out[GW-1:0]), r);
        check({tag, " busy"},  int'(busy), b);
    endtask

    task automatic do_wr(input logic [1:0] sel, input logic inst, input int v);
        wr_en = 1'b1; wr_sel = sel; wr_instant = inst; wr_data = GW'(v);
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'b00; wr_instant = 1'b0;
    endtask

    task automatic do_zc(input logic [1:0] m);
        zc_pulse = m;
        @(negedge clk);
        zc_pulse = 2'b00;
    endtask

    task automatic do_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R7 reset pin low", 0, 0, 0);
        mute_n = 1'b1;
        repeat (3) @(negedge clk);
        chk_all("R7 pin high no arm", 0, 0, 0);

        // R1 sweep over codes and channels
        for (int k = 0; k < 8; k++) begin
            int ch = k % 2;
            int v  = (k * 29 + 5) & 8'hff;
            logic [1:0] sel = (ch == 1) ? 2'b10 : 2'b01;
            do_wr(sel, 1'b0, v);
            chk_all("R1 armed", el, er, int'(sel));
            do_zc(~sel);
            chk_all("R1 other zc ignored", el, er, int'(sel));
            do_zc(sel);
            if (ch == 1) el = v; else er = v;
            chk_all("R1 commit on zc", el, er, 0);
        end

        // R2 timeout
        do_wr(2'b10, 1'b0, 8'h40);
        for (int t = 1; t < TMO; t++) begin
            do_tick();
            chk_all("R2 before timeout", el, er, 2);
        end
        do_tick();
        el = 8'h40;
        chk_all("R2 at timeout", el, er, 0);

        // R3 rewrite restarts count
        do_wr(2'b01, 1'b0, 8'h50);
        do_tick(); do_tick();
        do_wr(2'b01, 1'b0, 8'h60);
        for (int t = 1; t < TMO; t++) begin
            do_tick();
            chk_all("R3 restarted", el, er, 1);
        end
        do_tick();
        er = 8'h60;
        chk_all("R3 new value only", el, er, 0);

        // R4/R5 both channels, independent commits
        do_wr(2'b11, 1'b0, 8'h70);
        chk_all("R4 both busy", el, er, 3);
        do_zc(2'b01);
        er = 8'h70;
        chk_all("R5 right first", el, er, 2);
        do_zc(2'b10);
        el = 8'h70;
        chk_all("R5 left second", el, er, 0);

        // R6 instant
        do_wr(2'b10, 1'b1, 8'h21);
        el = 8'h21;
        chk_all("R6 instant left", el, er, 0);
        do_wr(2'b11, 1'b1, 8'h22);
        el = 8'h22; er = 8'h22;
        chk_all("R6 instant both", el, er, 0);

        // R11 coincident crossing and timeout
        do_wr(2'b01, 1'b0, 8'h33);
        for (int t = 1; t < TMO; t++) do_tick();
        zc_pulse = 2'b01; tick = 1'b1;
        @(negedge clk);
        zc_pulse = 2'b00; tick = 1'b0;
        er = 8'h33;
        chk_all("R11 single commit", el, er, 0);
        do_tick();
        chk_all("R11 stays ready", el, er, 0);

        // R8 mute pin
        mute_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk_all("R8 fall arms", el, er, 3);
        do_zc(2'b11);
        chk_all("R8 muted", 0, 0, 0);
        do_wr(2'b10, 1'b0, 8'h44);
        chk_all("R8 write while muted", 0, 0, 2);
        do_zc(2'b10);
        chk_all("R8 stays muted", 0, 0, 0);
        mute_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk_all("R8 rise arms", 0, 0, 3);
        for (int t = 0; t < TMO; t++) do_tick();
        el = 8'h44;
        chk_all("R8 restored", el, er, 0);

        // R9 test mode
        test_mode = 1'b1;
        @(negedge clk);
        chk_all("R9 outputs muted", 0, 0, 0);
        do_wr(2'b10, 1'b0, 8'h55);
        check("R9 normal write ignored busy", int'(busy), 0);
        do_wr(2'b01, 1'b1, 8'h56);
        check("R9 instant write ignored busy", int'(busy), 0);
        test_mode = 1'b0;
        @(negedge clk);
        chk_all("R9 after exit", el, er, 0);
        do_zc(2'b11);
        chk_all("R9 nothing pending", el, er, 0);

        // R10 force latch
        test_mode = 1'b1;
        force_en = 1'b1; wr_data = 8'h77;
        @(negedge clk);
        force_en = 1'b0;
        chk_all("R10 still muted in test", 0, 0, 0);
        test_mode = 1'b0;
        @(negedge clk);
        el = 8'h77; er = 8'h77;
        chk_all("R10 forced both", el, er, 0);

        // R7 reset mid-operation
        do_wr(2'b11, 1'b0, 8'h12);
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R7 reset again", 0, 0, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule